// File: doc/BRIEF.md
# Paging Codeword Double-Error Corrector

This block cleans up one 32-bit paging codeword at a time. A word holds 21 information bits in positions 31..11, ten cyclic check bits in positions 10..1 and an even-parity bit in position 0. The block divides the 31-bit protected part by the generator polynomial to get a 10-bit syndrome. It then walks a candidate error position across the 31 protected bits, one position per clock. At each step it compares the residue against the single-error syndrome of every other position in parallel. This repairs any one or two flipped bits. It does not need a 1024-entry lookup table.

After repair, the block recomputes the overall parity. Address words and message words are then treated differently. An address word with bad parity is flagged for rejection. A message word is never rejected, whatever its parity. A word whose syndrome cannot be explained by one or two flips is passed through untouched and flagged as uncorrectable.

A new word is taken while the block is idle. The result arrives as a one-cycle strobe between 1 and 31 clocks later.

Top module: `pager_bch_fixer`

## Requirements
- R1: After reset, out_valid, busy, out_word, out_nfix, out_fail and out_reject are all zero.
- R2: When in_valid is high and busy is low, the word is captured and busy is high on the next cycle. An in_valid that arrives while busy is high is ignored: it produces neither a result nor a change to the pending one.
- R3: A word is valid when the polynomial whose x^k coefficient is bit k+1 (k = 0..30) is divisible by x^10+x^9+x^8+x^6+x^5+x^3+1. For a word with a zero syndrome, out_word equals the input word, out_nfix is 0 and out_fail is 0.
- R4: Flipping any single bit among bits 31..1 of a valid word is undone. The result carries out_nfix = 1 and out_fail = 0.
- R5: Flipping any two distinct bits among bits 31..1 of a valid word is undone. The result carries out_nfix = 2 and out_fail = 0.
- R6: When the syndrome is non-zero and no pattern of one or two flips matches it, out_fail is 1, out_nfix is 0 and out_word equals the input word.
- R7: Bit 0 is never altered, and every result without out_fail has a zero syndrome.
- R8: out_reject is 1 exactly when bit 31 of out_word is 0 (an address word) and the XOR of all 32 bits of out_word is 1. A word whose bit 31 is 1 (a message word) is never rejected.
- R9: out_valid is a single-cycle pulse. It arrives between 1 and 31 cycles after the capture cycle, and busy falls with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Offers in_word for decoding |
| in_word | input | 32 | Received codeword |
| busy | output | 1 | A decode is in progress; new offers are ignored |
| out_valid | output | 1 | One-cycle result strobe |
| out_word | output | 32 | Corrected codeword |
| out_nfix | output | 2 | Number of bits flipped (0, 1 or 2) |
| out_fail | output | 1 | Syndrome not explained by one or two flips |
| out_reject | output | 1 | Address word with failed overall parity |

## Verification
The assertions assume that in_valid is only meaningful while busy is low. The bench respects this by waiting for each result before offering the next word, with one deliberate exception: a single offer made mid-decode to show that it is dropped. The assertions also assume that the error bound holds only for up to two flips. The bench therefore checks residue-free output only for words that a brute-force search over all one- and two-bit patterns can explain, and it confines three-bit damage to tests of the fail and miscorrect paths.

// File: rtl/pager_bch_fixer.sv
module pager_bch_fixer #(
  parameter logic [10:0] GEN = 11'b11101101001
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_word,
  output logic        busy,
  output logic        out_valid,
  output logic [31:0] out_word,
  output logic [1:0]  out_nfix,
  output logic        out_fail,
  output logic        out_reject
);
  localparam int NC = 10;
  localparam int NB = 31;
  localparam int IW = $clog2(NB);
  localparam logic [IW-1:0] LAST = IW'(NB - 1);

  function automatic logic [NC-1:0] xpow(input int p);
    logic [NC-1:0] r;
    r = NC'(1);
    for (int k = 0; k < p; k++)
      r = {r[NC-2:0], 1'b0} ^ (r[NC-1] ? GEN[NC-1:0] : '0);
    return r;
  endfunction

  function automatic logic [NC-1:0] syn_of(input logic [NB-1:0] c);
    logic [NC-1:0] r;
    r = '0;
    for (int k = NB - 1; k >= 0; k--)
      r = {r[NC-2:0], c[k]} ^ (r[NC-1] ? GEN[NC-1:0] : '0);
    return r;
  endfunction

  logic [NC-1:0] spos [NB];
  logic [31:0]   word_q;
  logic [NC-1:0] syn_q;
  logic [IW-1:0] idx;
  logic [NB-1:0] hit;
  logic [NC-1:0] cand;

  assign cand = syn_q ^ spos[idx];

  for (genvar j = 0; j < NB; j++) begin : g_cmp
    assign spos[j] = xpow(j);
    assign hit[j]  = (cand == spos[j]);
  end

  wire           clean  = (syn_q == '0);
  wire           single = !clean && (cand == '0);
  wire           dbl    = !clean && !single && (|hit);
  wire           done   = clean || single || dbl || (idx == LAST);
  wire [NB-1:0]  own    = NB'(1) << idx;
  wire [NB-1:0]  fixv   = single ? own : (dbl ? (own | hit) : '0);
  wire [31:0]    fixed  = word_q ^ {fixv, 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      out_valid  <= 1'b0;
      out_word   <= '0;
      out_nfix   <= '0;
      out_fail   <= 1'b0;
      out_reject <= 1'b0;
      word_q     <= '0;
      syn_q      <= '0;
      idx        <= '0;
    end else begin
      out_valid <= 1'b0;
      if (!busy) begin
        if (in_valid) begin
          word_q <= in_word;
          syn_q  <= syn_of(in_word[31:1]);
          idx    <= '0;
          busy   <= 1'b1;
        end
      end else if (done) begin
        busy       <= 1'b0;
        out_valid  <= 1'b1;
        out_word   <= fixed;
        out_nfix   <= single ? 2'd1 : (dbl ? 2'd2 : 2'd0);
        out_fail   <= !(clean || single || dbl);
        out_reject <= !fixed[31] && (^fixed);
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  AST_ACCEPT:     assert property (@(posedge clk) disable iff (!rst_n) (in_valid && !busy) |=> busy); // R2
  AST_IDX_RANGE:  assert property (@(posedge clk) disable iff (!rst_n) busy |-> (idx <= LAST)); // R9
  AST_PULSE:      assert property (@(posedge clk) disable iff (!rst_n) out_valid |=> !out_valid); // R9
  AST_BUSY_FALL:  assert property (@(posedge clk) disable iff (!rst_n) $rose(out_valid) |-> !busy); // R9
  AST_CLEAN_OUT:  assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !out_fail) |-> (syn_of(out_word[31:1]) == '0)); // R7
  AST_FAIL_NOFIX: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && out_fail) |-> (out_nfix == 2'd0)); // R6
  AST_MSG_KEEP:   assert property (@(posedge clk) disable iff (!rst_n) (out_valid && out_word[31]) |-> !out_reject); // R8
endmodule

// File: tb/sim_pager_bch_fixer.sv
module sim_pager_bch_fixer;
  localparam logic [10:0] G = 11'b11101101001;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_word = '0;
  logic        busy, out_valid, out_fail, out_reject;
  logic [31:0] out_word;
  logic [1:0]  out_nfix;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  pager_bch_fixer u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .busy(busy), .out_valid(out_valid), .out_word(out_word),
    .out_nfix(out_nfix), .out_fail(out_fail), .out_reject(out_reject)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] rem31(input logic [30:0] v);
    logic [30:0] t;
    t = v;
    for (int k = 30; k >= 10; k--)
      if (t[k]) t = t ^ (31'(G) << (k - 10));
    return t[9:0];
  endfunction

  function automatic logic [31:0] encode(input logic [20:0] d);
    logic [31:0] w;
    w = {d, 11'b0};
    w[10:1] = rem31({d, 10'b0});
    w[0] = ^w[31:1];
    return w;
  endfunction

  logic [31:0] e_word;
  int          e_nfix;
  bit          e_fail, e_rej;

  task automatic ref_dec(input logic [31:0] w);
    logic [9:0] s;
    bit found;
    s = rem31(w[31:1]);
    e_word = w; e_nfix = 0; e_fail = 0; found = 0;
    if (s != 0) begin
      for (int p = 0; p < 31 && !found; p++)
        if (rem31(31'(1) << p) == s) begin
          e_word = w ^ (32'd1 << (p + 1)); e_nfix = 1; found = 1;
        end
      for (int p = 0; p < 31 && !found; p++)
        for (int q = p + 1; q < 31 && !found; q++)
          if ((rem31(31'(1) << p) ^ rem31(31'(1) << q)) == s) begin
            e_word = w ^ (32'd1 << (p + 1)) ^ (32'd1 << (q + 1)); e_nfix = 2; found = 1;
          end
      if (!found) e_fail = 1;
    end
    e_rej = !e_word[31] && (^e_word);
  endtask

  int lat;

  task automatic run(input logic [31:0] w, input string req);
    @(negedge clk);
    in_valid = 1'b1; in_word = w;
    @(negedge clk);
    in_valid = 1'b0;
    chk(busy, "R2 busy after accept", {31'b0, busy}, 32'd1);
    lat = 0;
    while (!out_valid && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    chk(out_valid && lat >= 1 && lat <= 31 && !busy, "R9 latency", lat, 31);
    ref_dec(w);
    chk(out_word == e_word, {req, " word"}, out_word, e_word);
    chk(out_nfix == 2'(e_nfix), {req, " nfix"}, {30'b0, out_nfix}, e_nfix);
    chk(out_fail == e_fail, {req, " fail (R6)"}, {31'b0, out_fail}, {31'b0, e_fail});
    chk(out_reject == e_rej, {req, " reject (R8)"}, {31'b0, out_reject}, {31'b0, e_rej});
    chk(out_word[0] == w[0], "R7 parity bit kept", {31'b0, out_word[0]}, {31'b0, w[0]});
    @(negedge clk);
    chk(!out_valid, "R9 single pulse", {31'b0, out_valid}, 32'd0);
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] base [4];
    logic [31:0] w;
    int extra;
    repeat (3) @(negedge clk);
    chk(!out_valid && !busy && out_word == 0 && out_nfix == 0 && !out_fail && !out_reject,
        "R1 reset state", out_word, 32'd0);
    rst_n = 1'b1;

    base[0] = encode(21'h000000);
    base[1] = encode(21'h0ABCDE);
    base[2] = encode(21'h1F0F0F);
    base[3] = encode(21'h15A5A5);

    for (int b = 0; b < 4; b++) begin
      run(base[b], "R3 clean");
      chk(out_nfix == 0 && !out_fail, "R3 clean flags", {30'b0, out_nfix}, 32'd0);
    end

    for (int b = 0; b < 4; b++)
      for (int p = 1; p < 32; p++) begin
        run(base[b] ^ (32'd1 << p), "R4 single");
        chk(out_word == base[b] && out_nfix == 1, "R4 exact", out_word, base[b]);
      end

    for (int b = 1; b < 4; b += 2)
      for (int p = 1; p < 32; p++)
        for (int q = p + 1; q < 32; q++) begin
          run(base[b] ^ (32'd1 << p) ^ (32'd1 << q), "R5 double");
          chk(out_word == base[b] && out_nfix == 2, "R5 exact", out_word, base[b]);
        end

    for (int n = 0; n < 200; n++) begin
      int a, c, d;
      w = encode(21'($urandom));
      a = 1 + ($urandom % 31);
      c = 1 + ((a + ($urandom % 30)) % 31);
      do d = 1 + ($urandom % 31); while (d == a || d == c);
      if (c == a) c = (a % 31) + 1;
      if (d == c) d = (c % 31) + 1;
      if (d == a) d = (d % 31) + 1;
      run(w ^ (32'd1 << a) ^ (32'd1 << c) ^ (32'd1 << d), "R6 triple");
    end

    w = encode(21'h0BEEF0);
    w[31] = 1'b0; w = encode(w[31:11]);
    run(w ^ 32'd1, "R8 address bad parity");
    chk(out_reject && out_word == (w ^ 32'd1), "R8 address rejected", {31'b0, out_reject}, 32'd1);
    w = encode(21'h1BEEF0);
    run(w ^ 32'd1, "R8 message bad parity");
    chk(!out_reject && out_nfix == 0 && !out_fail, "R8 message accepted", {31'b0, out_reject}, 32'd0);
    w = encode(21'h0BEEF0);
    run(w ^ (32'd1 << 5), "R8 address fixed good parity");
    chk(!out_reject && out_word == w, "R8 address fixed", out_word, w);

    w = encode(21'h0F00F0) ^ (32'd1 << 31);
    @(negedge clk);
    in_valid = 1'b1; in_word = w;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (5) @(negedge clk);
    in_valid = 1'b1; in_word = encode(21'h123456) ^ 32'h6;
    @(negedge clk);
    in_valid = 1'b0;
    lat = 0;
    while (!out_valid && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    chk(out_valid && out_word == encode(21'h0F00F0) && out_nfix == 1, "R2 busy offer ignored",
        out_word, encode(21'h0F00F0));
    extra = 0;
    repeat (40) begin
      @(negedge clk);
      if (out_valid) extra++;
    end
    chk(extra == 0 && !busy, "R2 no result from dropped offer", extra, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule